// File: doc/BRIEF.md
# Keyed Watchdog Timer with Early Warning

This block is a hardware watchdog. A host arms it, keeps it alive and disarms it, all through one control write that carries a command bit, an 8-bit start count and a 7-bit key. Once armed, an 8-bit counter steps down once per prescaler period. The prescaler divides the system clock by a fixed ratio, `TICK_DIV`, which defaults to 131072.

When the count sits at 1, the block raises a non-maskable interrupt. This gives software one prescaler period to save state. On the next step the block emits a one-cycle chip reset pulse and returns to its idle, unkeyed state.

Each accepted write after the first must carry the bitwise complement of the key from the previous accepted write. A write with any other key is dropped, so a runaway program that repeats the same store cannot keep the watchdog alive. The rule also prevents such a program from stopping it.

Top module: `wdog_top`

## Requirements
- R1: After `rst_ni` is released, the watchdog is idle and holds no reference key. `nmi_o` and `chip_rst_o` stay low for as long as no write is accepted.
- R2: While unkeyed, a write with `wr_cmd_i`=1 (start) is accepted whatever its key, and that key becomes the reference. While unkeyed, a write with `wr_cmd_i`=0 (stop) is ignored.
- R3: An accepted start loads the count N and clears the prescaler. The count then drops by one every `TICK_DIV` cycles. The first decrement comes `TICK_DIV` edges after the accepting edge.
- R4: `nmi_o` is high exactly while the watchdog runs with a count of 1. It falls on the next accepted write or when the reset fires.
- R5: The reset fires when the count is 1 or 0 and a prescaler period elapses, which is N×`TICK_DIV` edges after accepting a start with N≥1. `chip_rst_o` is then high for exactly one cycle. The block becomes idle and unkeyed again, so the next start is accepted with any key.
- R6: Once keyed, a write is accepted only when `wr_key_i` equals the reference key XOR 7'h7F. Any other write is ignored and leaves the count and its timing untouched.
- R7: A start accepted while running reloads the counter with the new count and restarts the prescaler.
- R8: An accepted stop halts the counter with no NMI and no reset. The reference key stays in force, so the next start must carry its complement.
- R9: A start with count 0 fires the reset after one prescaler period without ever raising `nmi_o`.
- R10: An accepted write in the same cycle as a prescaler step takes priority over both the decrement and the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Control write strobe, one cycle per write |
| wr_cmd_i | input | 1 | 1 = start/refresh, 0 = stop |
| wr_cnt_i | input | 8 | Start count loaded on an accepted write |
| wr_key_i | input | 7 | Key presented with the write |
| nmi_o | output | 1 | Non-maskable interrupt warning |
| chip_rst_o | output | 1 | One-cycle chip reset request |

## Verification
An accepted write takes effect on the edge that samples it. With count 1, `nmi_o` rises on that same edge. With a larger count N, it rises (N-1)×`TICK_DIV` edges later, and `chip_rst_o` pulses N×`TICK_DIV` edges after the accepting edge. The bench counts edges from the accepting edge and samples on falling edges. It checks directed cases one cycle before and on the due edge. It also compares a cycle model written from the requirements on every cycle of a random write stream with a small prescaler ratio.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int KEY_W = 7;
  localparam int CNT_W = 8;
  localparam logic [KEY_W-1:0] KEY_FLIP = {KEY_W{1'b1}};

  typedef enum logic {
    WD_STOP  = 1'b0,
    WD_START = 1'b1
  } wd_cmd_e;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned TICK_DIV = 131072
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick_o = run_i && (pre_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  pre_q <= '0;
    else if (clr_i || !run_i || pre_q == LAST)    pre_q <= '0;
    else                                          pre_q <= pre_q + 1'b1;
  end

  // consecutive steps are at least two cycles apart
  p_tick_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/wdog_key_gate.sv
module wdog_key_gate
  import wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  wd_cmd_e          cmd_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             clear_i,
  output logic             accept_o
);
  logic [KEY_W-1:0] ref_q;
  logic             armed_q;
  logic             key_ok;

  // unkeyed: only a start may set the first reference
  assign key_ok   = armed_q ? (key_i == (ref_q ^ KEY_FLIP)) : (cmd_i == WD_START);
  assign accept_o = wr_en_i && key_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q   <= '0;
      armed_q <= 1'b0;
    end else if (accept_o) begin
      ref_q   <= key_i;
      armed_q <= 1'b1;
    end else if (clear_i) begin
      armed_q <= 1'b0;
    end
  end

  p_ref_flip_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(armed_q) && ref_q != $past(ref_q))
      |-> (ref_q == ($past(ref_q) ^ KEY_FLIP)));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tick_i,
  output logic             running_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fire_o,
  output logic             chip_rst_o
);
  logic             running_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rst_q;

  // a load in the step cycle wins over decrement and reset
  assign fire_o = tick_i && running_q && !load_i && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      cnt_q     <= '0;
      rst_q     <= 1'b0;
    end else begin
      rst_q <= fire_o;
      if (load_i) begin
        running_q <= start_i;
        cnt_q     <= cnt_i;
      end else if (fire_o) begin
        running_q <= 1'b0;
        cnt_q     <= '0;
      end else if (tick_i && running_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign running_o  = running_q;
  assign cnt_o      = cnt_q;
  assign chip_rst_o = rst_q;

  p_rst_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_rst_o |=> !chip_rst_o);
  p_rst_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_rst_o |-> !running_q);
  p_cnt_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int unsigned TICK_DIV = 131072
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       wr_cmd_i,
  input  logic [7:0] wr_cnt_i,
  input  logic [6:0] wr_key_i,
  output logic       nmi_o,
  output logic       chip_rst_o
);
  logic             accept;
  logic             tick;
  logic             running;
  logic             fire;
  logic [CNT_W-1:0] cnt;
  wd_cmd_e          cmd;

  assign cmd = wd_cmd_e'(wr_cmd_i);

  wdog_key_gate u_key (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .cmd_i    (cmd),
    .key_i    (wr_key_i),
    .clear_i  (fire),
    .accept_o (accept)
  );

  wdog_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (running),
    .clr_i  (accept),
    .tick_o (tick)
  );

  wdog_counter u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .start_i    (cmd == WD_START),
    .cnt_i      (wr_cnt_i),
    .tick_i     (tick),
    .running_o  (running),
    .cnt_o      (cnt),
    .fire_o     (fire),
    .chip_rst_o (chip_rst_o)
  );

  assign nmi_o = running && (cnt == CNT_W'(1));

  p_nmi_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_o && !accept && !fire) |=> nmi_o);
  p_rst_after_run_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_rst_o |-> $past(running));
  p_stop_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cmd == WD_STOP) |=> (!nmi_o && !chip_rst_o));
endmodule

// File: tb/sim_wdog_top.sv
module sim_wdog_top;
  localparam int unsigned D = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_cmd = 1'b0;
  logic [7:0] wr_cnt = '0;
  logic [6:0] wr_key = '0;
  logic       nmi, crst;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int t_acc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdog_top #(.TICK_DIV(D)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_cmd_i(wr_cmd),
    .wr_cnt_i(wr_cnt), .wr_key_i(wr_key), .nmi_o(nmi), .chip_rst_o(crst)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // reference model built from R1..R10
  logic       m_run, m_kv, m_rstp;
  logic [7:0] m_cnt;
  logic [6:0] m_key;
  int         m_pre;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_run = 0; m_kv = 0; m_rstp = 0; m_cnt = 0; m_key = 0; m_pre = 0;
    end else begin
      bit acc, stp;
      acc = wr_en && (m_kv ? (wr_key == (m_key ^ 7'h7F)) : wr_cmd);
      stp = m_run && (m_pre == D - 1);
      m_rstp = 0;
      if (acc) begin
        m_key = wr_key; m_kv = 1; m_run = wr_cmd; m_cnt = wr_cnt; m_pre = 0;
      end else if (stp) begin
        m_pre = 0;
        if (m_cnt <= 1) begin
          m_rstp = 1; m_run = 0; m_cnt = 0; m_kv = 0;
        end else m_cnt = m_cnt - 1;
      end else if (m_run) m_pre = m_pre + 1;
      else m_pre = 0;
    end
  end

  always @(negedge clk) if (rst_ni && !done) begin
    checks++;
    if (nmi !== (m_run && m_cnt == 8'd1)) begin
      fails++;
      $display("FAIL R4 model nmi cyc=%0d act=%0b exp=%0b", cyc, nmi, m_run && m_cnt == 8'd1);
    end
    checks++;
    if (crst !== m_rstp) begin
      fails++;
      $display("FAIL R5 model chip_rst cyc=%0d act=%0b exp=%0b", cyc, crst, m_rstp);
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cyc=%0d act=%0b exp=%0b", req, cyc, act, exp);
    end
  endtask

  // called at a falling edge; accepted on the next rising edge
  task automatic wr(input logic c, input logic [7:0] n, input logic [6:0] k);
    wr_en = 1; wr_cmd = c; wr_cnt = n; wr_key = k;
    @(negedge clk);
    wr_en = 0;
    t_acc = cyc;
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  initial begin
    int t, t2;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 nmi idle", nmi, 0);
    chk("R1 rst idle", crst, 0);
    wait_to(cyc + 40);
    chk("R1 still idle", crst, 0);

    // R2: stop while unkeyed ignored, first start takes any key
    wr(0, 8'd5, 7'h11);
    wr(1, 8'd2, 7'h2A); t = t_acc;
    wait_to(t + D - 1); chk("R3 nmi early", nmi, 0);
    wait_to(t + D);     chk("R2 first start nmi", nmi, 1);
    // R6: same key again is rejected
    wr(1, 8'd9, 7'h2A);
    wait_to(t + 2*D - 1); chk("R6 bad key ignored nmi", nmi, 1);
    chk("R6 no early rst", crst, 0);
    wait_to(t + 2*D);     chk("R5 rst due", crst, 1);
    wait_to(t + 2*D + 1); chk("R5 single pulse", crst, 0);
    chk("R4 nmi cleared by rst", nmi, 0);
    // R5: unkeyed again, any key accepted; count 1 warns at once
    wr(1, 8'd1, 7'h2A); t = t_acc;
    chk("R5 rekey nmi", nmi, 1);
    // R10: refresh on the step edge beats the reset
    wait_to(t + D - 1);
    wr(1, 8'd4, 7'h55); t = t_acc;
    chk("R10 no rst", crst, 0);
    chk("R10 nmi cleared", nmi, 0);
    // R7: refresh reloads
    wait_to(t + 2*D);
    wr(1, 8'd3, 7'h2A); t2 = t_acc;
    wait_to(t + 3*D);      chk("R7 old deadline gone", nmi, 0);
    wait_to(t2 + 2*D);     chk("R7 new deadline", nmi, 1);
    // R8: stop, then same key rejected, inverse accepted
    wr(0, 8'd0, 7'h55);
    wait_to(cyc + 10*D);   chk("R8 stopped nmi", nmi, 0);
    chk("R8 stopped rst", crst, 0);
    wr(1, 8'd2, 7'h55);
    wait_to(cyc + 3*D);    chk("R8 stale key nmi", nmi, 0);
    wr(1, 8'd2, 7'h2A); t = t_acc;
    wait_to(t + D);        chk("R8 restart nmi", nmi, 1);
    // R9: count 0
    wr(1, 8'd0, 7'h55); t = t_acc;
    wait_to(t + D - 1);    chk("R9 no early rst", crst, 0);
    wait_to(t + D);        chk("R9 rst", crst, 1);
    chk("R9 no nmi", nmi, 0);

    // random writes checked by the model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 16 < 2) begin
        logic [6:0] k;
        k = (m_kv && ($urandom % 3 != 0)) ? (m_key ^ 7'h7F) : 7'($urandom);
        wr(($urandom % 4) != 0, 8'($urandom % 4), k);
      end else @(negedge clk);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule